// File: doc/BRIEF.md
# Interrupt Pending and Priority Tracker

This block tracks the interrupt vectors of one processor. It holds three 256-bit vector maps. The pending map records accepted requests. The in-service map records vectors whose handlers are running. The level map records vectors that arrived as level-triggered. It also holds an 8-bit task priority. From these it derives the processor priority and picks the vector that may be delivered next.

Upstream logic hands over a vector with a level/edge flag. The core acknowledges the offered vector, which moves it into service. The core writes end-of-interrupt when a handler is done. If the retired vector was level-triggered, the block emits a one-cycle broadcast that carries the vector number, so the source can re-arm. A disable input stops any vector from being offered.

Top module: `irq_prio_tracker`

## Requirements
- R1: The highest set vector of a map is the one with the largest index. A map with no bit set yields no candidate and no offer.
- R2: `proc_prio` equals the task priority when task-priority bits [7:4] are at least bits [7:4] of the highest in-service vector. Otherwise it equals that vector's bits [7:4] with bits [3:0] zero. An empty in-service map counts as vector 0.
- R3: The highest pending vector is offered only if its bits [7:4] are strictly greater than bits [7:4] of the highest in-service vector, taken as 0 when none is in service. The task priority does not gate the offer.
- R4: `ack_valid` sets the in-service bit of `ack_vec` and clears its pending bit.
- R5: `eoi_wr` clears the highest in-service bit. With nothing in service it changes no state and gives no broadcast.
- R6: When the vector retired by `eoi_wr` has its level bit set, that bit is cleared. `eoi_bcast` is then high for exactly the one cycle after the write, with `eoi_bcast_vec` equal to the vector. An edge vector gives no pulse.
- R7: An accept with `acc_level`=1 sets both the pending bit and the level bit. With `acc_level`=0 it sets only the pending bit.
- R8: A task-priority write stores `tpr_wdata[7:0]` and ignores bits [31:8].
- R9: While `unit_disable` is high at a clock edge, `dlv_valid` is low after that edge.
- R10: An accept and an acknowledge of the same vector in the same cycle leave its pending bit set. An acknowledge and an EOI that hit the same in-service bit leave it set.
- R11: `dlv_valid`/`dlv_vec` are registered. They reflect the maps as they stood before the edge, so a new request shows one cycle after the edge that stored it.
- R12: After reset all maps are empty, the task priority is 0, `proc_prio` is 0, and `dlv_valid` and `eoi_bcast` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Accept a vector into the pending map |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack_valid | input | 1 | Acknowledge: move `ack_vec` into service |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (low byte kept) |
| unit_disable | input | 1 | Suppresses delivery |
| dlv_valid | output | 1 | A deliverable vector is offered |
| dlv_vec | output | 8 | Offered vector |
| proc_prio | output | 8 | Current processor priority |
| eoi_bcast | output | 1 | One-cycle level EOI broadcast |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
Map and task-priority changes land on the edge that samples the strobe. `proc_prio` is derived from registered state, so it shows the new value right after that edge. `eoi_bcast` is registered on the same edge as the EOI. The offered vector trails by one more edge, because it is computed from the maps that existed before the edge. The bench drives each stimulus on a falling edge and samples one nanosecond after the next rising edge. At that point it advances a reference model. It compares the offer against the model state from before the edge, and compares the priority and broadcast against the state after it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned IPT_NUM_VEC = 256;
  localparam int unsigned IPT_CLS_W   = 4;
  localparam int unsigned IPT_TPR_W   = 8;
  localparam int unsigned IPT_BUS_W   = 32;

  typedef struct packed {
    logic       found;
    logic [7:0] idx;
  } ipt_pick_t;
endpackage

// File: rtl/ipt_scan.sv
module ipt_scan #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  // Ascending walk; the last hit is the highest index.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/ipt_bitmaps.sv
module ipt_bitmaps #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  input  logic [W-1:0] acc_vec,
  input  logic         acc_level,
  input  logic         ack_valid,
  input  logic [W-1:0] ack_vec,
  input  logic         eoi_do,
  input  logic [W-1:0] eoi_vec,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] isr_q,
  output logic [N-1:0] tmr_q
);
  logic [N-1:0] irr_d, isr_d, tmr_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam logic [W-1:0] IDX = W'(i);
    logic acc_hit, ack_hit, eoi_hit;
    assign acc_hit  = acc_valid && (acc_vec == IDX);
    assign ack_hit  = ack_valid && (ack_vec == IDX);
    assign eoi_hit  = eoi_do    && (eoi_vec == IDX);
    // set terms dominate clear terms
    assign irr_d[i] = acc_hit | (irr_q[i] & ~ack_hit);
    assign isr_d[i] = ack_hit | (isr_q[i] & ~eoi_hit);
    assign tmr_d[i] = (acc_hit & acc_level) | (tmr_q[i] & ~eoi_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/ipt_prio.sv
module ipt_prio #(
  parameter int unsigned W     = 8,
  parameter int unsigned CLS_W = 4
) (
  input  logic [W-1:0] tpr,
  input  logic         isr_found,
  input  logic [W-1:0] isr_idx,
  input  logic         irr_found,
  input  logic [W-1:0] irr_idx,
  input  logic         enable,
  output logic [W-1:0] ppr,
  output logic         offer_ok
);
  localparam int unsigned SUB_W = W - CLS_W;

  logic [W-1:0]     isr_eff;
  logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls;

  always_comb begin
    isr_eff = isr_found ? isr_idx : '0;
    isr_cls = isr_eff[W-1 -: CLS_W];
    tpr_cls = tpr[W-1 -: CLS_W];
    irr_cls = irr_idx[W-1 -: CLS_W];
    if (tpr_cls >= isr_cls) ppr = tpr;
    else                    ppr = {isr_cls, {SUB_W{1'b0}}};
    offer_ok = enable && irr_found && (irr_cls > isr_cls);
  end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_VEC = IPT_NUM_VEC,
  parameter int unsigned CLS_W   = IPT_CLS_W,
  parameter int unsigned BUS_W   = IPT_BUS_W,
  localparam int unsigned VW     = $clog2(NUM_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [VW-1:0] acc_vec,
  input  logic          acc_level,
  input  logic          ack_valid,
  input  logic [VW-1:0] ack_vec,
  input  logic          eoi_wr,
  input  logic          tpr_wr,
  input  logic [BUS_W-1:0] tpr_wdata,
  input  logic          unit_disable,
  output logic          dlv_valid,
  output logic [VW-1:0] dlv_vec,
  output logic [VW-1:0] proc_prio,
  output logic          eoi_bcast,
  output logic [VW-1:0] eoi_bcast_vec
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic               irr_found, isr_found;
  logic [VW-1:0]      irr_idx, isr_idx;
  logic [VW-1:0]      tpr_q, tpr_d;
  logic               offer_ok;
  logic               eoi_do, bcast_d;
  logic               dlv_valid_d;
  logic [VW-1:0]      dlv_vec_d;

  ipt_scan #(.N(NUM_VEC), .W(VW)) u_irr_scan (
    .bits(irr_q), .found(irr_found), .idx(irr_idx)
  );
  ipt_scan #(.N(NUM_VEC), .W(VW)) u_isr_scan (
    .bits(isr_q), .found(isr_found), .idx(isr_idx)
  );

  assign eoi_do = eoi_wr && isr_found;

  ipt_bitmaps #(.N(NUM_VEC), .W(VW)) u_maps (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .ack_valid(ack_valid), .ack_vec(ack_vec),
    .eoi_do(eoi_do), .eoi_vec(isr_idx),
    .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
  );

  ipt_prio #(.W(VW), .CLS_W(CLS_W)) u_prio (
    .tpr(tpr_q), .isr_found(isr_found), .isr_idx(isr_idx),
    .irr_found(irr_found), .irr_idx(irr_idx), .enable(!unit_disable),
    .ppr(proc_prio), .offer_ok(offer_ok)
  );

  // next-state
  always_comb begin
    tpr_d       = tpr_wdata[VW-1:0];
    bcast_d     = eoi_do && tmr_q[isr_idx];
    dlv_valid_d = offer_ok;
    dlv_vec_d   = offer_ok ? irr_idx : '0;
  end

  // task priority, enabled by write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_q <= '0;
    else if (tpr_wr) tpr_q <= tpr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid     <= 1'b0;
      dlv_vec       <= '0;
      eoi_bcast     <= 1'b0;
      eoi_bcast_vec <= '0;
    end else begin
      dlv_valid     <= dlv_valid_d;
      dlv_vec       <= dlv_vec_d;
      eoi_bcast     <= bcast_d;
      eoi_bcast_vec <= bcast_d ? isr_idx : '0;
    end
  end
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned CLS_W   = 4,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned VW      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               unit_disable,
  input logic               eoi_wr,
  input logic               eoi_bcast,
  input logic               dlv_valid,
  input logic [VW-1:0]      proc_prio,
  input logic [VW-1:0]      tpr_q,
  input logic               tpr_wr,
  input logic [BUS_W-1:0]   tpr_wdata,
  input logic               ack_valid,
  input logic [VW-1:0]      ack_vec,
  input logic               acc_valid,
  input logic [VW-1:0]      acc_vec,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q
);
  AST_DISABLED_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !$past(unit_disable)); // R9
  AST_BCAST_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> $past(eoi_wr)); // R6
  AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> isr_q[$past(ack_vec)]); // R4
  AST_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> irr_q[$past(acc_vec)]); // R10
  AST_TPR_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr |=> (tpr_q == $past(tpr_wdata[VW-1:0]))); // R8
  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    proc_prio[VW-1 -: CLS_W] >= tpr_q[VW-1 -: CLS_W]); // R2
endmodule

bind irq_prio_tracker ipt_checker #(
  .NUM_VEC(NUM_VEC), .CLS_W(CLS_W), .BUS_W(BUS_W), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_disable(unit_disable), .eoi_wr(eoi_wr),
  .eoi_bcast(eoi_bcast), .dlv_valid(dlv_valid), .proc_prio(proc_prio),
  .tpr_q(tpr_q), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
  .ack_valid(ack_valid), .ack_vec(ack_vec), .acc_valid(acc_valid),
  .acc_vec(acc_vec), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/irq_prio_tracker_bench.sv
`timescale 1ns/1ps
module irq_prio_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_level, ack_valid, eoi_wr, tpr_wr, unit_disable;
  logic [7:0]  acc_vec, ack_vec;
  logic [31:0] tpr_wdata;
  logic        dlv_valid, eoi_bcast;
  logic [7:0]  dlv_vec, proc_prio, eoi_bcast_vec;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state
  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr;

  always #2.5 clk = ~clk;

  irq_prio_tracker u_irq_prio_tracker (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
    .acc_level(acc_level), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .eoi_wr(eoi_wr), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
    .unit_disable(unit_disable), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
    .proc_prio(proc_prio), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec)
  );

  function automatic int top_bit(logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] exp_ppr(logic [7:0] tpr, logic [255:0] isr);
    int s = top_bit(isr);
    logic [7:0] sv = (s < 0) ? 8'd0 : 8'(s);
    return (tpr[7:4] >= sv[7:4]) ? tpr : {sv[7:4], 4'h0};
  endfunction

  task automatic chk(string tag, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Drive at falling edge, sample 1 ns after the rising edge.
  task automatic step(logic av, logic [7:0] avec, logic alvl, logic kv,
                      logic [7:0] kvec, logic ew, logic tw, logic [31:0] twd,
                      logic dis, string tag);
    int h, s, scls;
    logic ev; logic [7:0] evec;
    logic bc; logic [7:0] bvec;
    acc_valid = av; acc_vec = avec; acc_level = alvl;
    ack_valid = kv; ack_vec = kvec; eoi_wr = ew;
    tpr_wr = tw; tpr_wdata = twd; unit_disable = dis;
    // offer computed from state before the edge
    h = top_bit(m_irr); s = top_bit(m_isr);
    scls = (s < 0) ? 0 : (s >> 4);
    ev   = !dis && (h >= 0) && ((h >> 4) > scls);
    evec = ev ? 8'(h) : 8'd0;
    bc   = ew && (s >= 0) && m_tmr[s];
    bvec = bc ? 8'(s) : 8'd0;
    // state update
    if (ew && s >= 0) begin m_isr[s] = 1'b0; m_tmr[s] = 1'b0; end
    if (kv) begin m_isr[kvec] = 1'b1; m_irr[kvec] = 1'b0; end
    if (av) begin m_irr[avec] = 1'b1; if (alvl) m_tmr[avec] = 1'b1; end
    if (tw) m_tpr = twd[7:0];
    @(posedge clk); #1;
    chk(tag, "dlv_valid", dlv_valid, ev);
    if (ev) chk(tag, "dlv_vec", dlv_vec, evec);
    chk(tag, "proc_prio", proc_prio, exp_ppr(m_tpr, m_isr));
    chk(tag, "eoi_bcast", eoi_bcast, bc);
    if (bc) chk(tag, "eoi_bcast_vec", eoi_bcast_vec, bvec);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed = 32'h1f2e3d4c;
    void'($urandom(seed));
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
    rst_n = 1'b0;
    acc_valid = 0; acc_vec = 0; acc_level = 0; ack_valid = 0; ack_vec = 0;
    eoi_wr = 0; tpr_wr = 0; tpr_wdata = 0; unit_disable = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "dlv_valid", dlv_valid, 0);
    chk("R12", "proc_prio", proc_prio, 0);
    chk("R12", "eoi_bcast", eoi_bcast, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: edge accept shows one edge later
    step(1, 8'h35, 0, 0, 0, 0, 0, 0, 0, "R11");
    idle("R11");
    // R3: class 0 never offered; R1 higher vector wins
    step(1, 8'h0A, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle("R1");
    // R4 ack, R2 ppr from in-service class
    step(0, 0, 0, 1, 8'h35, 0, 0, 0, 0, "R4");
    idle("R2");
    // R8 upper write bits ignored
    step(0, 0, 0, 0, 0, 0, 1, 32'hABCD_1247, 0, "R8");
    idle("R8");
    // R7 level accept, same class as in service: R3 not offered
    step(1, 8'h36, 1, 0, 0, 0, 0, 0, 0, "R7");
    idle("R3");
    step(1, 8'h52, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle("R3");
    // R9 disable blocks offer
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    // R5/R6 edge EOI: no broadcast
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 8'h36, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
    idle("R6");
    // R5 EOI on empty in-service map
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    idle("R5");
    // R10 accept and ack of same vector
    step(1, 8'h80, 0, 1, 8'h80, 0, 0, 0, 0, "R10");
    idle("R10");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 1, 32'h0, 0, "R5");
    idle("R1");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic av, alvl, kv, ew, tw, dis;
      logic [7:0] avec, kvec;
      av   = ($urandom % 100) < 45;
      avec = 8'($urandom % 256);
      alvl = ($urandom % 100) < 30;
      kv = 1'b0; kvec = 8'd0;
      if (dlv_valid && ($urandom % 100) < 50) begin kv = 1'b1; kvec = dlv_vec; end
      else if (($urandom % 100) < 4) begin kv = 1'b1; kvec = 8'($urandom % 256); end
      ew  = ($urandom % 100) < 18;
      tw  = ($urandom % 100) < 5;
      dis = ($urandom % 100) < 4;
      step(av, avec, alvl, kv, kvec, ew, tw, $urandom, dis, "R1/R2/R3");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule